// File: doc/BRIEF.md
# Ladder Timer Unit

A single timer element of the kind used by relay-style control programs. One engine provides three modes: delay on energize, delay on de-energize, and retentive delay on energize. It is driven by a rung-condition input and a separate clear input. An internal prescaler divides the system clock into a fine tick of one hundredth of a second and a coarse tick of one second, and a select input picks which one advances the timer.

The block holds a 15-bit-range preset and a 15-bit-range elapsed count, each in a 16-bit word. Both can be loaded through a small write port. It reports an enable bit that mirrors the rung, a done bit, a timed output, and the live values of both words. A controller evaluates one rung per cycle and feeds the result in. The timer's status then comes back on the next cycle.

Top module: `ladder_timer`

## Requirements
- R1: The fine tick fires once every `CYC_PER_FAST` clocks, counted from the release of reset, and the coarse tick fires on every `FAST_PER_SLOW`-th fine tick. `base_sel_i` = 1 selects the coarse tick and `base_sel_i` = 0 selects the fine tick. The elapsed count advances only on the selected tick.
- R2: `en_o` equals the value `rung_i` had in the previous cycle.
- R3: In delay-on mode (`mode_i` 2'b00, and 2'b11 behaves the same), the elapsed count rises by one on each selected tick while the rung is true. `dn_o` is 1 in the cycle after the count is at or above the preset with the rung true.
- R4: In delay-on mode, a false rung sets the elapsed count to 0 and `dn_o` to 0 on the next cycle.
- R5: In delay-off mode (`mode_i` 2'b01), a true rung holds the count at 0 and sets `dn_o` to 1. After the rung falls, `dn_o` stays 1 while the count rises on ticks. It drops in the cycle after the count reaches the preset.
- R6: In retentive mode (`mode_i` 2'b10), the count holds its value while the rung is false and resumes from it when the rung returns. `dn_o` is 1 whenever the count is at or above the preset.
- R7: The count never rises beyond the preset. Once it is at or above the preset, ticks leave it unchanged.
- R8: `res_i` sets the count and `dn_o` to 0 on the next cycle in every mode. It takes priority over an elapsed-count write and over timing in the same cycle.
- R9: A write with `wr_sel_i` = 0 loads the preset and a write with `wr_sel_i` = 1 loads the elapsed count, both visible on the next cycle. Data above 32767 is stored as 32767. An elapsed-count write takes priority over timing.
- R10: The preset is compared live every cycle. A preset lowered below the count makes `dn_o` 1 in the cycle after the new preset is held (R3, R6 modes).
- R11: `q_o` always equals `dn_o`.
- R12: During reset, `acc_o`, `preset_o`, `dn_o`, `q_o` and `en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rung_i | input | 1 | Rung condition |
| res_i | input | 1 | Clear of count and done |
| mode_i | input | 2 | 00 delay-on, 01 delay-off, 10 retentive, 11 as 00 |
| base_sel_i | input | 1 | 1 coarse tick, 0 fine tick |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 preset, 1 elapsed count |
| wr_data_i | input | 16 | Write data, saturated to 32767 |
| en_o | output | 1 | Registered rung condition |
| dn_o | output | 1 | Done bit |
| q_o | output | 1 | Timed output |
| acc_o | output | 16 | Elapsed count |
| preset_o | output | 16 | Preset |

## Verification
Every result is due exactly one clock after the edge that samples its inputs: `en_o`, the count, `dn_o`/`q_o` and both written words. The only exception is a preset change, which reaches `dn_o` one clock after the preset register itself updates, so two clocks after the write. The tick is combinational from the prescaler counters, so a tick in cycle k moves the count visible in cycle k+1. The bench drives inputs just after a rising edge and advances a reference model on each rising edge using the same pre-edge input values. It compares all outputs 1 ns after that edge, which keeps every check on the cycle where its result is due.

// File: rtl/ladder_timer_pkg.sv
// Shared types and helpers for the ladder timer unit.
// Assumes a 16-bit value word whose usable range is 0 .. 2**15-1.
package ladder_timer_pkg;

    localparam int VAL_W   = 16;
    localparam int VAL_MAX = (1 << (VAL_W - 1)) - 1;

    typedef enum logic [1:0] {
        TMODE_ON     = 2'b00,
        TMODE_OFF    = 2'b01,
        TMODE_RET    = 2'b10,
        TMODE_ON_ALT = 2'b11
    } tmode_e;

    // Saturate a raw write value to the legal range.
    function automatic logic [VAL_W-1:0] sat_val(input logic [VAL_W-1:0] d);
        if (d > VAL_W'(VAL_MAX)) return VAL_W'(VAL_MAX);
        return d;
    endfunction

endpackage

// File: rtl/timer_tickgen.sv
// Two-stage time-base prescaler.
// Produces a fine tick every CYC_PER_FAST clocks and a coarse tick on every
// FAST_PER_SLOW-th fine tick; the selected one drives the timer.
// Assumes CYC_PER_FAST >= 1 and FAST_PER_SLOW >= 1.
module timer_tickgen #(
    parameter int CYC_PER_FAST  = 100000,
    parameter int FAST_PER_SLOW = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_sel,
    output logic tick
);
    localparam int FW = (CYC_PER_FAST  > 1) ? $clog2(CYC_PER_FAST)  : 1;
    localparam int SW = (FAST_PER_SLOW > 1) ? $clog2(FAST_PER_SLOW) : 1;

    logic [FW-1:0] fcnt;
    logic [SW-1:0] scnt;
    logic          fast_tick;
    logic          slow_tick;

    // Tick decode from the current counter values.
    always_comb begin
        fast_tick = (fcnt == FW'(CYC_PER_FAST - 1));
        slow_tick = fast_tick && (scnt == SW'(FAST_PER_SLOW - 1));
        tick      = base_sel ? slow_tick : fast_tick;
    end

    // Fine-stage divider.
    always_ff @(posedge clk) begin
        if (!rst_n)         fcnt <= '0;
        else if (fast_tick) fcnt <= '0;
        else                fcnt <= fcnt + 1'b1;
    end

    // Coarse-stage divider, advanced by fine ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)         scnt <= '0;
        else if (slow_tick) scnt <= '0;
        else if (fast_tick) scnt <= scnt + 1'b1;
    end

    // R1: fine ticks are separated by idle cycles when the divider exceeds one.
    assert_fast_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (CYC_PER_FAST > 1 && fast_tick) |=> !fast_tick);

    // R1: a coarse tick only ever coincides with a fine tick boundary.
    assert_slow_on_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && CYC_PER_FAST > 1) |=> (fcnt == FW'(0)));

endmodule

// File: rtl/timer_cfg.sv
// Write-port decoder and preset register.
// Holds the preset; turns elapsed-count writes into a load strobe for the
// engine. Both paths saturate data to the legal range.
module timer_cfg
    import ladder_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    output logic [VAL_W-1:0] preset,
    output logic             acc_ld,
    output logic [VAL_W-1:0] acc_ld_val
);
    logic [VAL_W-1:0] wr_sat;

    // Saturate incoming data and decode the elapsed-count load.
    always_comb begin
        wr_sat     = sat_val(wr_data);
        acc_ld     = wr_en && wr_sel;
        acc_ld_val = wr_sat;
    end

    // Preset register.
    always_ff @(posedge clk) begin
        if (!rst_n)                preset <= '0;
        else if (wr_en && !wr_sel) preset <= wr_sat;
    end

    // R9: a preset write lands, saturated, on the next cycle.
    assert_preset_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (preset == sat_val($past(wr_data))));

    // R9: with no preset write the preset holds.
    assert_preset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_sel) |=> $stable(preset));

endmodule

// File: rtl/timer_engine.sv
// Timing engine shared by the three modes.
// Priority per cycle: clear input, then elapsed-count load, then the mode's
// timing rule. Preset is used combinationally, so changes act at once.
module timer_engine
    import ladder_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rung,
    input  logic             clr,
    input  tmode_e           mode,
    input  logic             tick,
    input  logic [VAL_W-1:0] preset,
    input  logic             acc_ld,
    input  logic [VAL_W-1:0] acc_ld_val,
    output logic [VAL_W-1:0] acc,
    output logic             done,
    output logic             en
);
    logic [VAL_W-1:0] acc_nx;
    logic             done_nx;
    logic             is_on;
    logic             can_step;

    // Next-state of elapsed count and done bit.
    always_comb begin
        is_on    = (mode == TMODE_ON) || (mode == TMODE_ON_ALT);
        can_step = tick && (acc < preset);
        acc_nx   = acc;
        done_nx  = done;
        if (clr) begin
            acc_nx  = '0;
            done_nx = 1'b0;
        end else begin
            if (acc_ld) begin
                acc_nx = acc_ld_val;
            end else if (is_on) begin
                if (!rung)         acc_nx = '0;
                else if (can_step) acc_nx = acc + 1'b1;
            end else if (mode == TMODE_RET) begin
                if (rung && can_step) acc_nx = acc + 1'b1;
            end else begin
                if (rung)                  acc_nx = '0;
                else if (done && can_step) acc_nx = acc + 1'b1;
            end
            if (is_on)                  done_nx = rung && (acc_nx >= preset);
            else if (mode == TMODE_RET) done_nx = (acc_nx >= preset);
            else                        done_nx = rung || (done && (acc_nx < preset));
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            done <= 1'b0;
            en   <= 1'b0;
        end else begin
            acc  <= acc_nx;
            done <= done_nx;
            en   <= rung;
        end
    end

    // R8: the clear input wins over everything.
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0 && !done));

    // R2: enable mirrors the rung one cycle late.
    assert_en_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en == $past(rung)));

    // R4: delay-on with a false rung zeroes the count and done.
    assert_on_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_on && !rung && !clr && !acc_ld) |=> (acc == '0 && !done));

    // R6: retentive mode keeps its count while the rung is false.
    assert_ret_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMODE_RET && !rung && !clr && !acc_ld) |=> $stable(acc));

    // R7: a count at or past the preset is never advanced.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc_ld && acc >= preset) |=> (acc <= $past(acc)));

    // R5: a true rung in delay-off mode energizes the output.
    assert_off_energize_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TMODE_OFF && rung && !clr) |=> done);

endmodule

// File: rtl/ladder_timer.sv
// Ladder timer unit top: prescaler, write port / preset, timing engine.
// Assumes inputs are synchronous to clk. Timed output equals the done bit.
module ladder_timer
    import ladder_timer_pkg::*;
#(
    parameter int CYC_PER_FAST  = 100000,
    parameter int FAST_PER_SLOW = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rung_i,
    input  logic        res_i,
    input  logic [1:0]  mode_i,
    input  logic        base_sel_i,
    input  logic        wr_en_i,
    input  logic        wr_sel_i,
    input  logic [15:0] wr_data_i,
    output logic        en_o,
    output logic        dn_o,
    output logic        q_o,
    output logic [15:0] acc_o,
    output logic [15:0] preset_o
);
    logic             tick;
    logic [VAL_W-1:0] preset;
    logic             acc_ld;
    logic [VAL_W-1:0] acc_ld_val;
    logic             done;
    tmode_e           mode;

    // Mode decode to the enum.
    always_comb mode = tmode_e'(mode_i);

    timer_tickgen #(
        .CYC_PER_FAST (CYC_PER_FAST),
        .FAST_PER_SLOW(FAST_PER_SLOW)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .base_sel(base_sel_i),
        .tick    (tick)
    );

    timer_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_sel    (wr_sel_i),
        .wr_data   (wr_data_i),
        .preset    (preset),
        .acc_ld    (acc_ld),
        .acc_ld_val(acc_ld_val)
    );

    timer_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .rung      (rung_i),
        .clr       (res_i),
        .mode      (mode),
        .tick      (tick),
        .preset    (preset),
        .acc_ld    (acc_ld),
        .acc_ld_val(acc_ld_val),
        .acc       (acc_o),
        .done      (done),
        .en        (en_o)
    );

    // Output drive.
    always_comb begin
        dn_o     = done;
        q_o      = done;
        preset_o = preset;
    end

    // R12: the reset state is all zero.
    assert_reset_state_R12: assert property (@(posedge clk)
        !rst_n |=> (acc_o == '0 && preset_o == '0 && !dn_o && !en_o));

endmodule

// File: tb/ladder_timer_tb.sv
module ladder_timer_tb;
    localparam int CPF = 3;
    localparam int FPS = 4;
    localparam int MAXV = 32767;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rung = 1'b0, res = 1'b0, base_sel = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [15:0] wr_data = '0;
    logic en_o, dn_o, q_o;
    logic [15:0] acc_o, preset_o;

    int checks = 0, errors = 0;
    bit finished = 0;
    string tag = "R12";

    // reference model state
    int m_f = 0, m_s = 0;
    logic [15:0] m_acc = '0, m_pre = '0;
    logic m_dn = 0, m_en = 0;

    always #2.5 clk = ~clk;

    ladder_timer #(.CYC_PER_FAST(CPF), .FAST_PER_SLOW(FPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rung_i(rung), .res_i(res), .mode_i(mode),
        .base_sel_i(base_sel), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .en_o(en_o), .dn_o(dn_o), .q_o(q_o),
        .acc_o(acc_o), .preset_o(preset_o));

    function automatic logic [15:0] sat(input logic [15:0] d);
        return (d > 16'(MAXV)) ? 16'(MAXV) : d;
    endfunction

    // Reference model advanced on each rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_f = 0; m_s = 0; m_acc = '0; m_pre = '0; m_dn = 0; m_en = 0;
        end else begin
            bit fast, slow, tk, on_m, step;
            logic [15:0] a;
            logic d;
            fast = (m_f == CPF - 1);
            slow = fast && (m_s == FPS - 1);
            tk = base_sel ? slow : fast;
            on_m = (mode == 2'b00) || (mode == 2'b11);
            step = tk && (m_acc < m_pre);
            a = m_acc; d = m_dn;
            if (res) begin
                a = '0; d = 0;
            end else begin
                if (wr_en && wr_sel) a = sat(wr_data);
                else if (on_m) a = !rung ? 16'd0 : (step ? m_acc + 16'd1 : m_acc);
                else if (mode == 2'b10) a = (rung && step) ? m_acc + 16'd1 : m_acc;
                else a = rung ? 16'd0 : ((m_dn && step) ? m_acc + 16'd1 : m_acc);
                if (on_m) d = rung && (a >= m_pre);
                else if (mode == 2'b10) d = (a >= m_pre);
                else d = rung || (m_dn && (a < m_pre));
            end
            m_acc = a; m_dn = d; m_en = rung;
            if (wr_en && !wr_sel) m_pre = sat(wr_data);
            if (fast) begin
                m_f = 0;
                m_s = slow ? 0 : m_s + 1;
            end else m_f = m_f + 1;
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    // One clock: inputs already set; sample 1 ns after the edge.
    task automatic cyc();
        @(posedge clk);
        #1;
        chk(tag, "acc", int'(acc_o), int'(m_acc));
        chk(tag, "done", int'(dn_o), int'(m_dn));
        chk("R2", "en", int'(en_o), int'(m_en));
        chk("R11", "q", int'(q_o), int'(m_dn));
        chk("R9", "preset", int'(preset_o), int'(m_pre));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        #1;
        tag = "R12";
        run(3);
        chk("R12", "reset acc", int'(acc_o), 0);
        chk("R12", "reset done", int'(dn_o), 0);
        rst_n = 1;

        tag = "R9";
        wr(0, 16'd40000); run(1);
        chk("R9", "preset saturation", int'(preset_o), MAXV);
        wr(0, 16'd3);

        tag = "R1"; mode = 2'b00; base_sel = 1; rung = 1;
        run(60);
        chk("R1", "coarse ticks reach preset", int'(acc_o), 3);
        base_sel = 0; rung = 0; run(2);

        tag = "R7"; wr(0, 16'd5); rung = 1;
        run(40);
        chk("R7", "saturated at preset", int'(acc_o), 5);
        tag = "R4"; rung = 0; run(2);
        chk("R4", "drop clears", int'(acc_o), 0);

        tag = "R10"; mode = 2'b10; wr(0, 16'd30); rung = 1;
        run(20);
        wr(0, 16'd2); run(2);
        chk("R10", "lowered preset sets done", int'(dn_o), 1);

        tag = "R6"; wr(0, 16'd30); rung = 0; run(10);
        rung = 1; run(6);

        tag = "R8"; res = 1; wr_en = 1; wr_sel = 1; wr_data = 16'd100;
        cyc();
        wr_en = 0;
        chk("R8", "clear beats load", int'(acc_o), 0);
        res = 0; rung = 0; run(2);

        tag = "R5"; mode = 2'b01; wr(0, 16'd4); rung = 1; run(5);
        rung = 0; run(30);
        chk("R5", "output dropped after delay", int'(dn_o), 0);

        tag = "R9"; mode = 2'b00; rung = 1; wr(1, 16'd50000); run(2);

        // Constrained random segments.
        for (int seg = 0; seg < 60; seg++) begin
            mode = 2'($urandom_range(0, 3));
            base_sel = ($urandom_range(0, 4) == 0);
            tag = (mode == 2'b01) ? "R5" : (mode == 2'b10) ? "R6" : "R3";
            for (int k = 0; k < 50; k++) begin
                if ($urandom_range(0, 9) == 0) rung = ~rung;
                res = ($urandom_range(0, 40) == 0);
                wr_en = ($urandom_range(0, 25) == 0);
                wr_sel = $urandom_range(0, 1);
                wr_data = ($urandom_range(0, 9) == 0) ? 16'($urandom)
                                                      : 16'($urandom_range(0, 12));
                cyc();
            end
            res = 0; wr_en = 0;
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule